// File: doc/BRIEF.md
# Base and Limit Address Relocation Unit

This block converts the logical addresses issued by a running process into physical addresses under a contiguous-partition memory scheme. Each process owns one contiguous region of physical memory. A relocation register holds the start of that region, and a bound register holds the highest logical address the process may touch. On every request the logical address is first compared against the bound. If it passes, the relocation value is added to give the physical address. If it does not pass, a segmentation fault is raised and no physical access is issued.

The operating system reloads the relocation and bound pair as one unit through a configuration port each time it switches processes. The port only takes effect while the privilege input indicates supervisor mode. A load attempted from user mode changes nothing and raises a one-cycle privilege-error pulse. After reset the unit is unconfigured, and every access faults until the first supervisor load. Each result appears one clock cycle after its request.

Top module: `seg_reloc_unit`

## Requirements
- R1: While reset (rst_n low, active low) is applied and in the first cycle after it, pa_vld_o, segv_o and priv_err_o are 0 and pa_o is all zeros. Both configuration registers reset to zero and the unit is unconfigured.
- R2: Until the first supervisor-mode configuration load has taken effect, every request (req_i=1) produces segv_o=1 and pa_vld_o=0 in the following cycle, whatever the logical address.
- R3: When the unit is configured, a request with lad_i not greater than the bound produces pa_vld_o=1, segv_o=0 and pa_o = relocation + lad_i exactly one clock cycle later.
- R4: When the unit is configured, a request with lad_i greater than the bound produces segv_o=1 one cycle later, with pa_vld_o=0 and pa_o all zeros. pa_vld_o and segv_o are never high together, and pa_o is zero whenever pa_vld_o is 0.
- R5: A request with lad_i exactly equal to the bound is translated and does not fault.
- R6: A configuration load (cfg_we_i=1 with priv_i=1, where 1 means supervisor and 0 means user) replaces the relocation with cfg_base_i and the bound with cfg_limit_i at the same clock edge. A request presented in the same cycle as the load is still translated with the previous pair. Requests from the next cycle on use the new pair.
- R7: A configuration load attempted with priv_i=0 leaves both registers and the configured state unchanged, and it sets priv_err_o to 1 for exactly the following cycle. priv_err_o is 0 in every other cycle.
- R8: In a cycle with req_i=0, the following cycle has pa_vld_o=0 and segv_o=0.
- R9: The relocation add is taken modulo 2^PA_W, so a sum that passes the top of the physical space wraps to low addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request for this cycle |
| lad_i | input | LA_W | Logical address of the request |
| priv_i | input | 1 | Current mode: 1 supervisor, 0 user |
| cfg_we_i | input | 1 | Load request for the relocation and bound pair |
| cfg_base_i | input | PA_W | New relocation value |
| cfg_limit_i | input | LA_W | New bound: highest legal logical address |
| pa_o | output | PA_W | Translated physical address, zero when not valid |
| pa_vld_o | output | 1 | Translated access is valid |
| segv_o | output | 1 | Segmentation fault for the previous request |
| priv_err_o | output | 1 | One-cycle pulse after a user-mode load attempt |

## Verification
The hardest case to reach from the ports is a configuration load that arrives in the same cycle as a request. The request must be judged against the outgoing pair, and the next request against the incoming one. Directed steps set this up twice: once when the unit goes from unconfigured to configured, and once during a process switch where the old bound accepts an address that the new bound rejects. The random phase then mixes loads from both privilege modes with requests. Logical addresses are drawn close to the current bound so that the equality boundary and the bound plus one are hit often, and a relocation near the top of the physical space exercises the wrap.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;
   // privilege level presented with each cycle
   typedef enum logic {
      MODE_USER  = 1'b0,
      MODE_SUPER = 1'b1
   } priv_mode_e;

   // outcome of one bounds check
   typedef enum logic [1:0] {
      RES_IDLE  = 2'b00,
      RES_OK    = 2'b01,
      RES_FAULT = 2'b10
   } xlat_res_e;
endpackage

// File: rtl/seg_bound_regs.sv
module seg_bound_regs
   import seg_reloc_pkg::*;
#(
   parameter int LA_W = 16,
   parameter int PA_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic            priv_i,
   input  logic [PA_W-1:0] base_i,
   input  logic [LA_W-1:0] lim_i,
   output logic [PA_W-1:0] base_o,
   output logic [LA_W-1:0] lim_o,
   output logic            armed_o,
   output logic            priv_err_o
);
   logic            super_w;
   logic [PA_W-1:0] base_q;
   logic [LA_W-1:0] lim_q;
   logic            armed_q;
   logic            perr_q;

   assign super_w = (priv_mode_e'(priv_i) == MODE_SUPER);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         lim_q   <= '0;
         armed_q <= 1'b0;
         perr_q  <= 1'b0;
      end else begin
         perr_q <= we_i & ~super_w;
         if (we_i && super_w) begin
            base_q  <= base_i;
            lim_q   <= lim_i;
            armed_q <= 1'b1;
         end
      end
   end

   assign base_o     = base_q;
   assign lim_o      = lim_q;
   assign armed_o    = armed_q;
   assign priv_err_o = perr_q;
endmodule

// File: rtl/seg_limit_cmp.sv
module seg_limit_cmp
   import seg_reloc_pkg::*;
#(
   parameter int LA_W = 16
) (
   input  logic            req_i,
   input  logic            armed_i,
   input  logic [LA_W-1:0] lad_i,
   input  logic [LA_W-1:0] lim_i,
   output xlat_res_e       res_o
);
   logic over_w;

   assign over_w = (lad_i > lim_i) | ~armed_i;

   always_comb begin
      if (!req_i)      res_o = RES_IDLE;
      else if (over_w) res_o = RES_FAULT;
      else             res_o = RES_OK;
   end
endmodule

// File: rtl/seg_reloc_add.sv
module seg_reloc_add #(
   parameter int LA_W = 16,
   parameter int PA_W = 20
) (
   input  logic [PA_W-1:0] base_i,
   input  logic [LA_W-1:0] lad_i,
   output logic [PA_W-1:0] sum_o
);
   localparam int EXT_W = PA_W - LA_W;

   generate
      if (EXT_W == 0) begin : g_same
         assign sum_o = base_i + lad_i;
      end else begin : g_ext
         logic [PA_W-1:0] lad_ext;
         assign lad_ext = {{EXT_W{1'b0}}, lad_i};
         assign sum_o   = base_i + lad_ext;
      end
   endgenerate
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
   import seg_reloc_pkg::*;
#(
   parameter int LA_W = 16,
   parameter int PA_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic [LA_W-1:0] lad_i,
   input  logic            priv_i,
   input  logic            cfg_we_i,
   input  logic [PA_W-1:0] cfg_base_i,
   input  logic [LA_W-1:0] cfg_limit_i,
   output logic [PA_W-1:0] pa_o,
   output logic            pa_vld_o,
   output logic            segv_o,
   output logic            priv_err_o
);
   generate
      if (LA_W < 1) begin : g_bad_la
         $error("LA_W must be at least 1");
      end
      if (PA_W < LA_W) begin : g_bad_pa
         $error("PA_W must not be narrower than LA_W");
      end
   endgenerate

   logic [PA_W-1:0] base_q;
   logic [LA_W-1:0] lim_q;
   logic            armed_q;
   logic [PA_W-1:0] sum_w;
   xlat_res_e       res_w;

   logic [PA_W-1:0] pa_q;
   logic            vld_q;
   logic            segv_q;

   seg_bound_regs #(.LA_W(LA_W), .PA_W(PA_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (cfg_we_i),
      .priv_i     (priv_i),
      .base_i     (cfg_base_i),
      .lim_i      (cfg_limit_i),
      .base_o     (base_q),
      .lim_o      (lim_q),
      .armed_o    (armed_q),
      .priv_err_o (priv_err_o)
   );

   seg_limit_cmp #(.LA_W(LA_W)) cmp_i (
      .req_i   (req_i),
      .armed_i (armed_q),
      .lad_i   (lad_i),
      .lim_i   (lim_q),
      .res_o   (res_w)
   );

   seg_reloc_add #(.LA_W(LA_W), .PA_W(PA_W)) add_i (
      .base_i (base_q),
      .lad_i  (lad_i),
      .sum_o  (sum_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pa_q   <= '0;
         vld_q  <= 1'b0;
         segv_q <= 1'b0;
      end else begin
         vld_q  <= (res_w == RES_OK);
         segv_q <= (res_w == RES_FAULT);
         pa_q   <= (res_w == RES_OK) ? sum_w : '0;
      end
   end

   assign pa_o     = pa_q;
   assign pa_vld_o = vld_q;
   assign segv_o   = segv_q;
endmodule

// File: rtl/seg_reloc_chk.sv
module seg_reloc_chk #(
   parameter int LA_W = 16,
   parameter int PA_W = 20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_i,
   input logic [LA_W-1:0] lad_i,
   input logic            priv_i,
   input logic            cfg_we_i,
   input logic [PA_W-1:0] pa_o,
   input logic            pa_vld_o,
   input logic            segv_o,
   input logic            priv_err_o,
   input logic [PA_W-1:0] base_q,
   input logic [LA_W-1:0] lim_q,
   input logic            armed_q
);
   logic [PA_W-1:0] want_pa;
   assign want_pa = base_q + PA_W'(lad_i);

   // R4
   excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pa_vld_o && segv_o));

   // R4
   pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pa_vld_o |-> (pa_o == '0));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!pa_vld_o && !segv_o));

   // R2
   unarmed_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !armed_q) |=> (segv_o && !pa_vld_o));

   // R3
   reloc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && armed_q && (lad_i <= lim_q)) |=> (pa_vld_o && (pa_o == $past(want_pa))));

   // R4
   over_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && (lad_i > lim_q)) |=> segv_o);

   // R7
   perr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && !priv_i) |=> priv_err_o);

   // R7
   perr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we_i && !priv_i) |=> !priv_err_o);

   // R7
   user_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && !priv_i) |=> ($stable(base_q) && $stable(lim_q) && $stable(armed_q)));
endmodule

bind seg_reloc_unit seg_reloc_chk #(.LA_W(LA_W), .PA_W(PA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .lad_i      (lad_i),
   .priv_i     (priv_i),
   .cfg_we_i   (cfg_we_i),
   .pa_o       (pa_o),
   .pa_vld_o   (pa_vld_o),
   .segv_o     (segv_o),
   .priv_err_o (priv_err_o),
   .base_q     (base_q),
   .lim_q      (lim_q),
   .armed_q    (armed_q)
);

// File: tb/seg_reloc_unit_tb.sv
`timescale 1ns/1ps
module seg_reloc_unit_tb_top;
   localparam int LA_W = 16;
   localparam int PA_W = 20;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            req_i;
   logic [LA_W-1:0] lad_i;
   logic            priv_i;
   logic            cfg_we_i;
   logic [PA_W-1:0] cfg_base_i;
   logic [LA_W-1:0] cfg_limit_i;
   logic [PA_W-1:0] pa_o;
   logic            pa_vld_o;
   logic            segv_o;
   logic            priv_err_o;

   int total = 0;
   int bad   = 0;

   // model state
   logic [PA_W-1:0] m_base  = '0;
   logic [LA_W-1:0] m_lim   = '0;
   logic            m_armed = 1'b0;

   always #4 clk = ~clk;

   seg_reloc_unit #(.LA_W(LA_W), .PA_W(PA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .lad_i(lad_i), .priv_i(priv_i),
      .cfg_we_i(cfg_we_i), .cfg_base_i(cfg_base_i), .cfg_limit_i(cfg_limit_i),
      .pa_o(pa_o), .pa_vld_o(pa_vld_o), .segv_o(segv_o), .priv_err_o(priv_err_o)
   );

   function automatic logic [PA_W-1:0] calc_pa(input logic [PA_W-1:0] b, input logic [LA_W-1:0] a);
      logic [PA_W+1:0] wide;
      wide = {2'b00, b} + {{(PA_W+2-LA_W){1'b0}}, a};
      return wide[PA_W-1:0];
   endfunction

   task automatic check_out(input logic ev, input logic es, input logic [PA_W-1:0] ep,
                            input logic eperr, input string tag);
      total++;
      if (pa_vld_o !== ev || segv_o !== es || pa_o !== ep || priv_err_o !== eperr) begin
         bad++;
         $display("FAIL %s: got vld=%b segv=%b pa=%h perr=%b exp vld=%b segv=%b pa=%h perr=%b",
                  tag, pa_vld_o, segv_o, pa_o, priv_err_o, ev, es, ep, eperr);
      end
   endtask

   // one cycle: drive at negedge, check at next negedge
   task automatic cyc(input logic rq, input logic [LA_W-1:0] la, input logic pv,
                      input logic we, input logic [PA_W-1:0] nb, input logic [LA_W-1:0] nl,
                      input string tag);
      logic flt, ev, es, eperr;
      logic [PA_W-1:0] ep;
      flt   = !m_armed || (la > m_lim);
      ev    = rq && !flt;
      es    = rq && flt;
      ep    = ev ? calc_pa(m_base, la) : '0;
      eperr = we && !pv;
      req_i = rq; lad_i = la; priv_i = pv; cfg_we_i = we; cfg_base_i = nb; cfg_limit_i = nl;
      if (we && pv) begin
         m_base = nb; m_lim = nl; m_armed = 1'b1;
      end
      @(negedge clk);
      check_out(ev, es, ep, eperr, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h5eed_0017;
      void'($urandom(seed));
      rst_n = 1'b0; req_i = 0; lad_i = '0; priv_i = 0; cfg_we_i = 0;
      cfg_base_i = '0; cfg_limit_i = '0;
      repeat (3) @(negedge clk);
      check_out(1'b0, 1'b0, '0, 1'b0, "R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_out(1'b0, 1'b0, '0, 1'b0, "R1 after reset");

      cyc(1, 16'h0000, 1, 0, '0, '0, "R2 unarmed addr 0");
      cyc(1, 16'h1234, 0, 0, '0, '0, "R2 unarmed addr mid");
      cyc(0, 16'h0000, 0, 1, 20'h00100, 16'h00FF, "R7 user load pulse");
      cyc(1, 16'h0000, 0, 0, '0, '0, "R7 user load ignored still faults");
      cyc(1, 16'h0005, 1, 1, 20'h01000, 16'h0FFF, "R6 load with request uses old pair");
      cyc(1, 16'h0005, 0, 0, '0, '0, "R6 new pair active R3");
      cyc(1, 16'h0FFF, 0, 0, '0, '0, "R5 addr equals bound");
      cyc(1, 16'h1000, 0, 0, '0, '0, "R4 bound plus one");
      cyc(0, 16'h2000, 0, 0, '0, '0, "R8 idle cycle");
      cyc(0, 16'h0000, 0, 1, 20'h33333, 16'h0001, "R7 user load while armed");
      cyc(1, 16'h0FFF, 0, 0, '0, '0, "R7 bound unchanged after user load");
      cyc(0, 16'h0000, 1, 1, 20'hFFFF0, 16'hFFFF, "R6 load high base");
      cyc(1, 16'h0020, 0, 0, '0, '0, "R9 wrap past top");
      cyc(1, 16'hFFFF, 0, 0, '0, '0, "R9 wrap at max addr R5");
      cyc(1, 16'h0020, 1, 1, 20'h04000, 16'h0010, "R6 switch with request uses old pair");
      cyc(1, 16'h0020, 0, 0, '0, '0, "R6 switch new bound faults R4");
      cyc(1, 16'h0010, 1, 0, '0, '0, "R5 new bound equality");

      for (int i = 0; i < 600; i++) begin
         logic rq, pv, we;
         logic [LA_W-1:0] la, nl;
         logic [PA_W-1:0] nb;
         int unsigned sel;
         rq  = ($urandom % 4) != 0;
         pv  = $urandom % 2;
         we  = ($urandom % 8) == 0;
         nb  = PA_W'($urandom);
         nl  = LA_W'($urandom);
         sel = $urandom % 4;
         case (sel)
            0: la = m_lim;
            1: la = m_lim + 1'b1;
            2: la = m_lim - LA_W'($urandom % 4);
            default: la = LA_W'($urandom);
         endcase
         cyc(rq, la, pv, we, nb, nl, "R3 R4 R6 R7 random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule